// File: doc/BRIEF.md
# ADC Result Limit and Zero-Crossing Monitor

This block watches the stream of signed conversion results leaving an analog-to-digital converter. Every result arrives with a valid strobe, the index of the channel it belongs to, the raw value and an offset. The block returns the offset-corrected value one cycle later. For the channel named with the sample, it also checks for three events. The raw value may fall strictly below the channel's low limit. It may rise strictly above the channel's high limit. The sign of the corrected value may flip relative to that channel's previous sample, in the direction the channel's zero-crossing mode selects.

Each event sets a sticky per-channel status bit, provided its class is enabled. Software clears status bits by writing ones to them. One active-high error interrupt gathers every set status bit whose class is enabled. Configuration uses a single-cycle write port: an address made of a 3-bit register kind and a channel index, plus write data.

Top module: `adc_limit_monitor`

## Requirements
- R1: After reset all status bits, `err_irq` and `out_valid` are 0. Every low limit resets to -32768, every high limit to +32767, every zero-crossing mode to 00, and the control bits to 0.
- R2: A sample on channel c whose raw value is strictly less than c's low limit sets `lo_flags[c]` at the clock edge that takes the sample, if low-event enable (control bit 0) is 1. A value equal to the limit sets nothing.
- R3: A sample on channel c whose raw value is strictly greater than c's high limit sets `hi_flags[c]` at the same edge, if high-event enable (control bit 1) is 1. A value equal to the limit sets nothing.
- R4: Both limit comparisons use the raw value, never the corrected one. One cycle after `res_valid`, `out_valid` is 1 and `out_result` equals raw minus offset, wrapped to 16 bits. `out_valid` is 0 one cycle after a cycle without `res_valid`.
- R5: The sign of a sample is bit 15 of its corrected value. Zero-crossing mode per channel: 00 off, 01 non-negative to negative, 10 negative to non-negative, 11 either way. A matching flip sets `zc_flags[c]` if zero-crossing enable (control bit 2) is 1.
- R6: A channel only remembers a previous sign while control bit 2 is 1 and its mode is not 00. The first sample after reset, or after tracking resumes, raises no zero-crossing event.
- R7: While an event's enable bit is 0, that event sets no status bit. A cycle without `res_valid` sets no status bit.
- R8: Status bits stay set until cleared by writing a one to them. Kind 4 clears low bits, kind 5 clears high bits and kind 6 clears zero-crossing bits, using write data bit c for channel c. An event in the same cycle as a clear of the same bit leaves the bit set.
- R9: `err_irq` is 1 exactly when some low bit is set with control bit 0 at 1, some high bit is set with bit 1 at 1, or some zero-crossing bit is set with bit 2 at 1. Clearing an enable masks the interrupt but keeps the status.
- R10: Write address is {kind[2:0], channel[2:0]}. Kind 0 writes the low limit, kind 1 the high limit, kind 2 the mode (data bits 1:0), and kind 3 the control bits (data bits 2:0, channel ignored). Writes with kind 7 change nothing. A configuration write takes effect at its clock edge and applies to samples taken at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | A new sample is present this cycle |
| res_chan | input | 3 | Channel of the sample |
| res_raw | input | 16 | Raw signed sample |
| res_offset | input | 16 | Offset subtracted to form the corrected value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | {register kind, channel} |
| cfg_wdata | input | 16 | Write data |
| out_valid | output | 1 | Corrected value is present |
| out_result | output | 16 | Raw minus offset |
| lo_flags | output | 8 | Sticky low-limit status, one bit per channel |
| hi_flags | output | 8 | Sticky high-limit status, one bit per channel |
| zc_flags | output | 8 | Sticky zero-crossing status, one bit per channel |
| err_irq | output | 1 | Combined error interrupt |

## Verification
A wrong limit register or a comparison against the corrected value shows up in the status bits one cycle after the sample that crosses the boundary. A stale or wrongly cleared previous-sign bit only shows up on the next sample of that channel, so the bench drives pairs and triples of samples per channel across enable changes. A broken clear or priority shows on the status outputs in the cycle after the write. A wrong mask shows on `err_irq` in the same cycle as the status.

// File: rtl/adc_mon_pkg.sv
// Shared encodings for the ADC result monitor: register kinds carried in the
// upper address bits, zero-crossing modes and control bit positions.
package adc_mon_pkg;
    typedef enum logic [2:0] {
        KIND_LO_LIM  = 3'd0,
        KIND_HI_LIM  = 3'd1,
        KIND_ZC_MODE = 3'd2,
        KIND_CTRL    = 3'd3,
        KIND_CLR_LO  = 3'd4,
        KIND_CLR_HI  = 3'd5,
        KIND_CLR_ZC  = 3'd6
    } reg_kind_e;

    // bit 0 selects falling (non-negative -> negative), bit 1 rising
    typedef enum logic [1:0] {
        ZC_OFF  = 2'b00,
        ZC_FALL = 2'b01,
        ZC_RISE = 2'b10,
        ZC_ANY  = 2'b11
    } zc_mode_e;

    localparam int KIND_W     = 3;
    localparam int CTRL_LO_EN = 0;
    localparam int CTRL_HI_EN = 1;
    localparam int CTRL_ZC_EN = 2;
endpackage

// File: rtl/adc_mon_cfg.sv
// Configuration registers of the monitor: per-channel limits and modes, the
// control enables, and decode of write-one-to-clear strobes.
// Assumes NUM_CH <= DATA_W so a clear mask fits in the write data.
module adc_mon_cfg
    import adc_mon_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16,
    parameter int CH_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [KIND_W-1:0]             cfg_kind,
    input  logic [CH_W-1:0]               cfg_chan,
    input  logic [DATA_W-1:0]             cfg_wdata,
    output logic [NUM_CH-1:0][DATA_W-1:0] lo_lim,
    output logic [NUM_CH-1:0][DATA_W-1:0] hi_lim,
    output logic [NUM_CH-1:0][1:0]        zc_mode,
    output logic                          en_lo,
    output logic                          en_hi,
    output logic                          en_zc,
    output logic [2:0][NUM_CH-1:0]        clr_mask
);
    localparam logic [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MAX_VAL = {1'b0, {(DATA_W-1){1'b1}}};

    logic [2:0] ctrl_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic hit;
        assign hit = cfg_we && (cfg_chan == CH_W'(c));

        // Holds the low limit of channel c
        always_ff @(posedge clk) begin
            if (!rst_n)                           lo_lim[c] <= MIN_VAL;
            else if (hit && cfg_kind == KIND_LO_LIM) lo_lim[c] <= cfg_wdata;
        end

        // Holds the high limit of channel c
        always_ff @(posedge clk) begin
            if (!rst_n)                           hi_lim[c] <= MAX_VAL;
            else if (hit && cfg_kind == KIND_HI_LIM) hi_lim[c] <= cfg_wdata;
        end

        // Holds the zero-crossing mode of channel c
        always_ff @(posedge clk) begin
            if (!rst_n)                            zc_mode[c] <= ZC_OFF;
            else if (hit && cfg_kind == KIND_ZC_MODE) zc_mode[c] <= cfg_wdata[1:0];
        end
    end

    // Holds the three event enables
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctrl_q <= '0;
        else if (cfg_we && cfg_kind == KIND_CTRL) ctrl_q <= cfg_wdata[2:0];
    end

    assign en_lo = ctrl_q[CTRL_LO_EN];
    assign en_hi = ctrl_q[CTRL_HI_EN];
    assign en_zc = ctrl_q[CTRL_ZC_EN];

    // Turns a clear write into a one-cycle per-channel mask (0 low, 1 high, 2 zc)
    always_comb begin
        clr_mask = '0;
        if (cfg_we) begin
            case (cfg_kind)
                KIND_CLR_LO: clr_mask[0] = cfg_wdata[NUM_CH-1:0];
                KIND_CLR_HI: clr_mask[1] = cfg_wdata[NUM_CH-1:0];
                KIND_CLR_ZC: clr_mask[2] = cfg_wdata[NUM_CH-1:0];
                default:     clr_mask    = '0;
            endcase
        end
    end
endmodule

// File: rtl/adc_mon_detect.sv
// Per-sample event detection: limit compares on the raw value, sign tracking
// per channel on the corrected value, and the registered corrected output.
// Assumes res_chan < NUM_CH when res_valid is high.
module adc_mon_detect
    import adc_mon_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16,
    parameter int CH_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          res_valid,
    input  logic [CH_W-1:0]               res_chan,
    input  logic [DATA_W-1:0]             res_raw,
    input  logic [DATA_W-1:0]             res_offset,
    input  logic [NUM_CH-1:0][DATA_W-1:0] lo_lim,
    input  logic [NUM_CH-1:0][DATA_W-1:0] hi_lim,
    input  logic [NUM_CH-1:0][1:0]        zc_mode,
    input  logic                          en_lo,
    input  logic                          en_hi,
    input  logic                          en_zc,
    output logic [2:0][NUM_CH-1:0]        events,
    output logic                          out_valid,
    output logic [DATA_W-1:0]             out_result
);
    logic [DATA_W-1:0] adj;
    logic              cur_neg;
    logic [NUM_CH-1:0] chan_hot;
    logic [NUM_CH-1:0] tracking;
    logic [NUM_CH-1:0] prev_ok;
    logic [NUM_CH-1:0] prev_neg;
    logic              below, above, flip_fall, flip_rise, zc_hit;
    logic [1:0]        sel_mode;

    assign adj      = res_raw - res_offset;
    assign cur_neg  = adj[DATA_W-1];
    assign chan_hot = NUM_CH'(1) << res_chan;
    assign sel_mode = zc_mode[res_chan];

    // Signed compares of the raw sample against the selected channel limits
    always_comb begin
        below = $signed(res_raw) < $signed(lo_lim[res_chan]);
        above = $signed(res_raw) > $signed(hi_lim[res_chan]);
    end

    // Direction of a sign change against the stored sign of the channel
    always_comb begin
        flip_fall = prev_ok[res_chan] && !prev_neg[res_chan] &&  cur_neg;
        flip_rise = prev_ok[res_chan] &&  prev_neg[res_chan] && !cur_neg;
        zc_hit    = tracking[res_chan] &&
                    ((sel_mode[0] && flip_fall) || (sel_mode[1] && flip_rise));
    end

    // Routes each enabled event to the bit of the sampled channel
    always_comb begin
        events[0] = (res_valid && en_lo && below)  ? chan_hot : '0;
        events[1] = (res_valid && en_hi && above)  ? chan_hot : '0;
        events[2] = (res_valid && zc_hit)          ? chan_hot : '0;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sign
        assign tracking[c] = en_zc && (zc_mode[c] != ZC_OFF);

        // Remembers the sign of the last tracked sample of channel c
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_ok[c]  <= 1'b0;
                prev_neg[c] <= 1'b0;
            end else if (!tracking[c]) begin
                prev_ok[c]  <= 1'b0;
            end else if (res_valid && res_chan == CH_W'(c)) begin
                prev_ok[c]  <= 1'b1;
                prev_neg[c] <= cur_neg;
            end
        end
    end

    // Registers the corrected value with its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= res_valid;
            if (res_valid) out_result <= adj;
        end
    end
endmodule

// File: rtl/adc_mon_status.sv
// Sticky status bits for the three event classes with write-one-to-clear,
// where a same-cycle event wins, and the masked combined interrupt.
module adc_mon_status #(
    parameter int NUM_CH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0][NUM_CH-1:0] events,
    input  logic [2:0][NUM_CH-1:0] clr_mask,
    input  logic [2:0]             class_en,
    output logic [2:0][NUM_CH-1:0] flags,
    output logic                   err_irq
);
    logic [2:0] class_pending;

    for (genvar k = 0; k < 3; k++) begin : g_class
        // Keeps the status bits of event class k
        always_ff @(posedge clk) begin
            if (!rst_n) flags[k] <= '0;
            else        flags[k] <= (flags[k] & ~clr_mask[k]) | events[k];
        end
        assign class_pending[k] = class_en[k] && (|flags[k]);
    end

    assign err_irq = |class_pending;
endmodule

// File: rtl/adc_limit_monitor.sv
// Top of the ADC result monitor: splits the write address, wires the
// configuration, detection and status parts together.
// Assumes one sample per cycle at most and NUM_CH <= DATA_W.
module adc_limit_monitor
    import adc_mon_pkg::*;
#(
    parameter  int NUM_CH = 8,
    parameter  int DATA_W = 16,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + KIND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [DATA_W-1:0] res_raw,
    input  logic [DATA_W-1:0] res_offset,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [NUM_CH-1:0] lo_flags,
    output logic [NUM_CH-1:0] hi_flags,
    output logic [NUM_CH-1:0] zc_flags,
    output logic              err_irq
);
    logic [NUM_CH-1:0][DATA_W-1:0] lo_lim, hi_lim;
    logic [NUM_CH-1:0][1:0]        zc_mode;
    logic                          en_lo, en_hi, en_zc;
    logic [2:0][NUM_CH-1:0]        clr_mask, events, flags;

    adc_mon_cfg #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_kind(cfg_addr[ADDR_W-1 -: KIND_W]), .cfg_chan(cfg_addr[CH_W-1:0]),
        .cfg_wdata(cfg_wdata), .lo_lim(lo_lim), .hi_lim(hi_lim), .zc_mode(zc_mode),
        .en_lo(en_lo), .en_hi(en_hi), .en_zc(en_zc), .clr_mask(clr_mask)
    );

    adc_mon_detect #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_detect (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_raw(res_raw), .res_offset(res_offset), .lo_lim(lo_lim), .hi_lim(hi_lim),
        .zc_mode(zc_mode), .en_lo(en_lo), .en_hi(en_hi), .en_zc(en_zc),
        .events(events), .out_valid(out_valid), .out_result(out_result)
    );

    adc_mon_status #(.NUM_CH(NUM_CH)) u_status (
        .clk(clk), .rst_n(rst_n), .events(events), .clr_mask(clr_mask),
        .class_en({en_zc, en_hi, en_lo}), .flags(flags), .err_irq(err_irq)
    );

    assign lo_flags = flags[0];
    assign hi_flags = flags[1];
    assign zc_flags = flags[2];
endmodule

// File: rtl/adc_limit_monitor_chk.sv
// Port-level properties of the ADC result monitor, bound to its top.
module adc_limit_monitor_chk #(
    parameter  int NUM_CH = 8,
    parameter  int DATA_W = 16,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_raw,
    input logic [DATA_W-1:0] res_offset,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic [NUM_CH-1:0] lo_flags,
    input logic [NUM_CH-1:0] hi_flags,
    input logic [NUM_CH-1:0] zc_flags,
    input logic              err_irq
);
    logic [DATA_W-1:0] diff_w;
    logic              clr_lo_wr, clr_hi_wr, clr_zc_wr;

    assign diff_w    = res_raw - res_offset;
    assign clr_lo_wr = cfg_we && cfg_addr[ADDR_W-1 -: 3] == 3'd4;
    assign clr_hi_wr = cfg_we && cfg_addr[ADDR_W-1 -: 3] == 3'd5;
    assign clr_zc_wr = cfg_we && cfg_addr[ADDR_W-1 -: 3] == 3'd6;

    // R9
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_flags == '0 && hi_flags == '0 && zc_flags == '0) |-> !err_irq);

    // R4
    adj_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (out_valid && out_result == $past(diff_w)));

    // R4
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> !out_valid);

    // R8
    lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_lo_wr |=> ((lo_flags & $past(lo_flags)) == $past(lo_flags)));

    // R8
    hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hi_wr |=> ((hi_flags & $past(hi_flags)) == $past(hi_flags)));

    // R8
    zc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_zc_wr |=> ((zc_flags & $past(zc_flags)) == $past(zc_flags)));

    // R7
    no_sample_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> ((lo_flags & ~$past(lo_flags)) == '0 &&
                        (hi_flags & ~$past(hi_flags)) == '0 &&
                        (zc_flags & ~$past(zc_flags)) == '0));

    // R2
    one_channel_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> $onehot0(lo_flags & ~$past(lo_flags)));
endmodule

bind adc_limit_monitor adc_limit_monitor_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_adc_limit_monitor.sv
`timescale 1ns/1ps
module test_adc_limit_monitor;
    localparam int K_LO = 0, K_HI = 1, K_ZM = 2, K_CTRL = 3;
    localparam int K_CLO = 4, K_CHI = 5, K_CZC = 6, K_BAD = 7;

    typedef struct {
        logic [15:0] res;
        logic [7:0]  lo, hi, zc;
        logic        irq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [2:0]  res_chan = '0;
    logic [15:0] res_raw = '0, res_offset = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        out_valid, err_irq;
    logic [15:0] out_result;
    logic [7:0]  lo_flags, hi_flags, zc_flags;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    exp_t q[$];

    // bench model state
    logic signed [15:0] m_lo[8], m_hi[8];
    logic [1:0]         m_zm[8];
    logic [2:0]         m_ctrl;
    bit                 m_pok[8], m_pneg[8];
    logic [7:0]         f_lo, f_hi, f_zc;

    adc_limit_monitor i_adc_limit_monitor (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_raw(res_raw), .res_offset(res_offset), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
        .out_result(out_result), .lo_flags(lo_flags), .hi_flags(hi_flags),
        .zc_flags(zc_flags), .err_irq(err_irq)
    );

    always #4 clk = ~clk;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic model_irq();
        return (m_ctrl[0] && |f_lo) || (m_ctrl[1] && |f_hi) || (m_ctrl[2] && |f_zc);
    endfunction

    // Drives one cycle of inputs and advances the model by one clock edge
    task automatic step(bit s, int ch, logic [15:0] raw, logic [15:0] off,
                        bit w, int kind, int wch, logic [15:0] data, string tag);
        logic [15:0] adj;
        logic [7:0]  ev_lo, ev_hi, ev_zc, c_lo, c_hi, c_zc;
        bit          neg, trk;
        exp_t        e;
        @(negedge clk);
        res_valid = s; res_chan = 3'(ch); res_raw = raw; res_offset = off;
        cfg_we = w; cfg_addr = {3'(kind), 3'(wch)}; cfg_wdata = data;
        ev_lo = '0; ev_hi = '0; ev_zc = '0; c_lo = '0; c_hi = '0; c_zc = '0;
        adj = raw - off;
        neg = adj[15];
        if (s) begin
            trk = m_ctrl[2] && m_zm[ch] != 2'b00;
            if (m_ctrl[0] && $signed(raw) < m_lo[ch]) ev_lo[ch] = 1'b1;
            if (m_ctrl[1] && $signed(raw) > m_hi[ch]) ev_hi[ch] = 1'b1;
            if (trk && m_pok[ch] &&
                ((m_zm[ch][0] && !m_pneg[ch] && neg) || (m_zm[ch][1] && m_pneg[ch] && !neg)))
                ev_zc[ch] = 1'b1;
            if (trk) begin m_pok[ch] = 1'b1; m_pneg[ch] = neg; end
        end
        if (w) begin
            case (kind)
                K_LO:   m_lo[wch] = data;
                K_HI:   m_hi[wch] = data;
                K_ZM:   m_zm[wch] = data[1:0];
                K_CTRL: m_ctrl = data[2:0];
                K_CLO:  c_lo = data[7:0];
                K_CHI:  c_hi = data[7:0];
                K_CZC:  c_zc = data[7:0];
                default: ;
            endcase
        end
        f_lo = (f_lo & ~c_lo) | ev_lo;
        f_hi = (f_hi & ~c_hi) | ev_hi;
        f_zc = (f_zc & ~c_zc) | ev_zc;
        for (int c = 0; c < 8; c++)
            if (!(m_ctrl[2] && m_zm[c] != 2'b00)) m_pok[c] = 1'b0;
        if (s) begin
            e.res = adj; e.lo = f_lo; e.hi = f_hi; e.zc = f_zc;
            e.irq = model_irq(); e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic smp(int ch, int raw, int off, string tag);
        step(1'b1, ch, 16'(raw), 16'(off), 1'b0, 0, 0, 16'h0, tag);
    endtask

    task automatic wr(int kind, int ch, int data);
        step(1'b0, 0, 16'h0, 16'h0, 1'b1, kind, ch, 16'(data), "");
    endtask

    task automatic idle();
        @(negedge clk);
        res_valid = 1'b0; cfg_we = 1'b0;
    endtask

    // Compares status outputs with the model at the current negedge
    task automatic check_now(string req);
        check(req, "lo_flags", 32'(lo_flags), 32'(f_lo));
        check(req, "hi_flags", 32'(hi_flags), 32'(f_hi));
        check(req, "zc_flags", 32'(zc_flags), 32'(f_zc));
        check(req, "err_irq",  32'(err_irq),  32'(model_irq()));
    endtask

    // Monitor: pops one expected item per produced result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                check("R4", "unexpected out_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "out_result", 32'(out_result), 32'(e.res));
                check(e.tag, "lo_flags",   32'(lo_flags),   32'(e.lo));
                check(e.tag, "hi_flags",   32'(hi_flags),   32'(e.hi));
                check(e.tag, "zc_flags",   32'(zc_flags),   32'(e.zc));
                check(e.tag, "err_irq",    32'(err_irq),    32'(e.irq));
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 8; c++) begin
            m_lo[c] = 16'sh8000; m_hi[c] = 16'sh7fff; m_zm[c] = 2'b00;
            m_pok[c] = 1'b0; m_pneg[c] = 1'b0;
        end
        m_ctrl = '0; f_lo = '0; f_hi = '0; f_zc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_now("R1");
        check("R1", "out_valid", 32'(out_valid), 32'd0);

        // R7 disabled events record nothing
        wr(K_LO, 2, -100);
        wr(K_HI, 2, 100);
        smp(2, -200, 0, "R7");
        smp(2, 200, 0, "R7");
        idle(); check_now("R7");

        // R2 low limit, strict
        wr(K_CTRL, 0, 3);
        smp(2, -101, 0, "R2");
        smp(2, -100, 0, "R2");
        smp(3, -32768, 0, "R2");
        wr(K_CLO, 0, 8'h04);
        idle(); check_now("R8");
        smp(2, -100, 0, "R2");

        // R3 / R4 high limit, raw value against limit
        smp(2, 100, 0, "R3");
        smp(2, 50, -100, "R4");
        smp(2, 101, 200, "R4");
        smp(2, -32768, 1, "R4");
        smp(4, 32767, 0, "R3");

        // R8 event wins over same-cycle clear; clear of other bits still works
        step(1'b1, 2, 16'(-300), 16'h0, 1'b1, K_CLO, 0, 16'h04, "R8");
        step(1'b1, 2, 16'(150), 16'h0, 1'b1, K_CHI, 0, 16'hff, "R8");
        idle(); check_now("R8");
        wr(K_CHI, 0, 8'hff);
        idle(); check_now("R8");

        // R9 masking by enables
        wr(K_CTRL, 0, 0);
        idle(); check_now("R9");
        wr(K_CTRL, 0, 1);
        idle(); check_now("R9");
        wr(K_CLO, 0, 8'hff);
        idle(); check_now("R9");

        // R5 / R6 zero crossing modes, sign of corrected value
        wr(K_ZM, 5, 1);
        wr(K_ZM, 6, 2);
        wr(K_ZM, 7, 3);
        wr(K_CTRL, 0, 7);
        smp(5, 10, 0, "R6");
        smp(5, 20, 30, "R5");
        smp(5, 10, 0, "R5");
        wr(K_CZC, 0, 8'hff);
        smp(5, -1, 0, "R5");
        smp(6, -5, 0, "R6");
        smp(6, 5, 0, "R5");
        smp(6, -5, 0, "R5");
        smp(7, 5, 0, "R6");
        wr(K_CZC, 0, 8'hff);
        smp(7, -5, 0, "R5");
        wr(K_CZC, 0, 8'hff);
        smp(7, 0, 0, "R5");
        wr(K_CZC, 0, 8'hff);
        smp(4, 9, 0, "R5");
        smp(4, -9, 0, "R5");

        // R6 tracking restarts after disable
        wr(K_CTRL, 0, 3);
        idle();
        wr(K_CTRL, 0, 7);
        smp(7, 5, 0, "R6");
        smp(7, -5, 0, "R6");
        wr(K_ZM, 6, 0);
        idle();
        wr(K_ZM, 6, 2);
        smp(6, 8, 0, "R6");

        // R10 unused kind changes nothing; limits are per channel
        wr(K_BAD, 2, 16'h7fff);
        wr(K_CLO, 0, 8'hff);
        idle(); check_now("R10");
        smp(2, -101, 0, "R10");
        smp(1, -101, 0, "R10");
        wr(K_LO, 1, 0);
        smp(1, -1, 0, "R10");
        idle(); idle();
        check_now("R8");
        check("R4", "queue drained", 32'(q.size()), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule